// File: doc/BRIEF.md
# Watchdog Counter Snapshot Reader

This block lets a bus-side processor read a down-counter that runs on its own, independent watchdog clock. The counter decrements once per watchdog clock, stops at zero, and can be reloaded from the watchdog side. A one-cycle read request on the bus clock starts a toggle handshake. The request toggle crosses into the watchdog domain through a synchronizer. There the live count is frozen into a hold register, and an acknowledge toggle crosses back.

When the acknowledge arrives, the frozen value is placed on the read data bus with a one-cycle valid pulse. Latency is bounded, and the value returned is already older than the live count. A request that arrives while a read is in flight is held, one deep. It starts as soon as the current handshake finishes, and a busy flag stays high for the whole time.

Top module: `wdsnap_top`

## Requirements
- R1: After reset the counter holds 0x0000FF, `rd_data` reads 0x000000FF, and `rd_busy` and `rd_valid` are low.
- R2: With `ld_en` low, the counter drops by one on every `wd_clk` edge and stays at zero once it gets there.
- R3: With `ld_en` high at a `wd_clk` edge, the counter takes `ld_value`, and this overrides the decrement.
- R4: When idle, `rd_req` raises `rd_busy` on the next `bus_clk` edge. The read then ends with exactly one `bus_clk` cycle of `rd_valid` high, and `rd_busy` falls in that same cycle unless another read is held.
- R5: Bits 23:0 of the returned `rd_data` lie between the counter value when the request was issued and the value when `rd_valid` is seen. The returned value is a stale snapshot, not the live count.
- R6: `rd_data[31:24]` is always zero.
- R7: The time from the bus edge that accepts a request to the bus edge that raises `rd_valid` is at most 6 `wd_clk` periods plus 6 `bus_clk` periods.
- R8: `rd_data` changes only in a cycle where `rd_valid` is high, and holds its value between reads.
- R9: A request made while busy is held, one deep, and starts when the current read completes, so it produces a second `rd_valid`. Any further requests made while one is already held are merged into it.
- R10: The hold register changes only together with the acknowledge toggle, so it is stable while the acknowledge crosses into the bus domain.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bus_clk | input | 1 | Bus-side clock |
| bus_rst_n | input | 1 | Bus-side active-low reset |
| rd_req | input | 1 | Single-cycle read request |
| rd_busy | output | 1 | Read in flight or held |
| rd_valid | output | 1 | One-cycle pulse: `rd_data` has a new snapshot |
| rd_data | output | 32 | Snapshot in bits 23:0; bits 31:24 are zero |
| wd_clk | input | 1 | Watchdog clock |
| wd_rst_n | input | 1 | Watchdog-side active-low reset |
| ld_en | input | 1 | Load strobe for the counter |
| ld_value | input | 24 | Value loaded into the counter |

## Verification
The assertions assume that each reset is held for several cycles of its own clock and released while the other domain is idle. They also assume that `ld_en` and `ld_value` change only away from `wd_clk` rising edges. The stimulus drives every input on the falling edge of the clock that samples it, with both resets applied together. No loads are issued while a read is in flight, because the bounds of R5 only hold when the counter moves monotonically during the read. The two clock periods are chosen so that their edges drift past each other, which covers every relative phase of the handshake.

// File: rtl/wdsnap_pkg.sv
package wdsnap_pkg;
   localparam int unsigned DEF_CNT_W   = 24;
   localparam int unsigned DEF_DATA_W  = 32;
   localparam int unsigned DEF_STAGES  = 2;
   localparam logic [23:0] DEF_RST_CNT = 24'h0000FF;
endpackage

// File: rtl/wdsnap_sync.sv
module wdsnap_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("wdsnap_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d};
   end

   assign q = chain_q[STAGES-1];
endmodule

// File: rtl/wdsnap_counter.sv
module wdsnap_counter #(
   parameter int unsigned     CNT_W   = 24,
   parameter logic [CNT_W-1:0] RST_CNT = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ld_en,
   input  logic [CNT_W-1:0] ld_value,
   output logic [CNT_W-1:0] count
);
   logic [CNT_W-1:0] cnt_q;
   logic             at_zero;

   assign at_zero = (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cnt_q <= RST_CNT;
      else if (ld_en)    cnt_q <= ld_value;
      else if (!at_zero) cnt_q <= cnt_q - CNT_W'(1);
   end

   assign count = cnt_q;

   a_r2_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == '0 && !ld_en) |=> (cnt_q == '0));
   a_r2_decrement: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q != '0 && !ld_en) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
   a_r3_load: assert property (@(posedge clk) disable iff (!rst_n)
      ld_en |=> (cnt_q == $past(ld_value)));
endmodule

// File: rtl/wdsnap_capture.sv
module wdsnap_capture #(
   parameter int unsigned      CNT_W   = 24,
   parameter int unsigned      STAGES  = 2,
   parameter logic [CNT_W-1:0] RST_CNT = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_tgl,
   input  logic [CNT_W-1:0] count,
   output logic [CNT_W-1:0] hold,
   output logic             ack_tgl
);
   logic             req_s;
   logic             ack_q;
   logic [CNT_W-1:0] hold_q;
   logic             grab;

   wdsnap_sync #(.STAGES(STAGES)) u_req_sync (
      .clk(clk), .rst_n(rst_n), .d(req_tgl), .q(req_s)
   );

   assign grab = (req_s != ack_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= RST_CNT;
         ack_q  <= 1'b0;
      end else if (grab) begin
         hold_q <= count;
         ack_q  <= ~ack_q;
      end
   end

   assign hold    = hold_q;
   assign ack_tgl = ack_q;

   a_r10_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(hold_q) |-> !$stable(ack_q));
endmodule

// File: rtl/wdsnap_top.sv
module wdsnap_top
   import wdsnap_pkg::*;
#(
   parameter int unsigned      CNT_W       = DEF_CNT_W,
   parameter int unsigned      DATA_W      = DEF_DATA_W,
   parameter int unsigned      SYNC_STAGES = DEF_STAGES,
   parameter logic [CNT_W-1:0] RST_CNT     = CNT_W'(DEF_RST_CNT)
) (
   input  logic              bus_clk,
   input  logic              bus_rst_n,
   input  logic              rd_req,
   output logic              rd_busy,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   input  logic              wd_clk,
   input  logic              wd_rst_n,
   input  logic              ld_en,
   input  logic [CNT_W-1:0]  ld_value
);
   localparam int unsigned PAD_W = DATA_W - CNT_W;

   if (CNT_W >= DATA_W) begin : g_bad_width
      $error("wdsnap_top: CNT_W must be narrower than DATA_W");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("wdsnap_top: SYNC_STAGES must be at least 2");
   end

   logic [CNT_W-1:0] live_cnt;
   logic [CNT_W-1:0] hold;
   logic             ack_tgl;
   logic             ack_s;

   logic              req_tgl_q;
   logic              busy_q;
   logic              pend_q;
   logic              valid_q;
   logic [DATA_W-1:0] data_q;
   logic              done;
   logic              start;

   wdsnap_counter #(.CNT_W(CNT_W), .RST_CNT(RST_CNT)) u_cnt (
      .clk(wd_clk), .rst_n(wd_rst_n), .ld_en(ld_en),
      .ld_value(ld_value), .count(live_cnt)
   );

   wdsnap_capture #(.CNT_W(CNT_W), .STAGES(SYNC_STAGES), .RST_CNT(RST_CNT)) u_cap (
      .clk(wd_clk), .rst_n(wd_rst_n), .req_tgl(req_tgl_q),
      .count(live_cnt), .hold(hold), .ack_tgl(ack_tgl)
   );

   wdsnap_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
      .clk(bus_clk), .rst_n(bus_rst_n), .d(ack_tgl), .q(ack_s)
   );

   assign done  = busy_q && (ack_s == req_tgl_q);
   assign start = busy_q ? (done && (pend_q || rd_req)) : rd_req;

   always_ff @(posedge bus_clk or negedge bus_rst_n) begin
      if (!bus_rst_n) begin
         req_tgl_q <= 1'b0;
         busy_q    <= 1'b0;
         pend_q    <= 1'b0;
         valid_q   <= 1'b0;
         data_q    <= DATA_W'(RST_CNT);
      end else begin
         valid_q <= done;
         if (done) data_q <= {{PAD_W{1'b0}}, hold};
         if (start) begin
            req_tgl_q <= ~req_tgl_q;
            busy_q    <= 1'b1;
            pend_q    <= 1'b0;
         end else begin
            if (done) busy_q <= 1'b0;
            if (busy_q && !done && rd_req) pend_q <= 1'b1;
         end
      end
   end

   assign rd_busy  = busy_q;
   assign rd_valid = valid_q;
   assign rd_data  = data_q;

   a_r6_reserved_zero: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
      data_q[DATA_W-1:CNT_W] == '0);
   a_r4_valid_pulse: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
      valid_q |=> !valid_q);
   a_r4_busy_rise: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
      (!busy_q && rd_req) |=> busy_q);
   a_r8_data_on_valid: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
      !$stable(data_q) |-> valid_q);
   a_r9_busy_kept: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
      (busy_q && !done) |=> busy_q);
   a_r9_pend_only_busy: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
      pend_q |-> busy_q);
endmodule

// File: tb/tb_wdsnap_top.sv
`timescale 1ns/100ps
module tb_wdsnap_top;
   localparam real BUS_PER = 20.0;
   localparam real WD_PER  = 37.3;

   logic        bus_clk = 1'b0, wd_clk = 1'b0;
   logic        bus_rst_n = 1'b0, wd_rst_n = 1'b0;
   logic        rd_req = 1'b0, ld_en = 1'b0;
   logic [23:0] ld_value = '0;
   logic        rd_busy, rd_valid;
   logic [31:0] rd_data;

   int checks = 0, errors = 0, vcount = 0;
   bit finished = 0;
   logic [23:0] mdl;

   always #(BUS_PER/2) bus_clk = ~bus_clk;
   always #(WD_PER/2)  wd_clk  = ~wd_clk;

   wdsnap_top dut (
      .bus_clk(bus_clk), .bus_rst_n(bus_rst_n), .rd_req(rd_req),
      .rd_busy(rd_busy), .rd_valid(rd_valid), .rd_data(rd_data),
      .wd_clk(wd_clk), .wd_rst_n(wd_rst_n), .ld_en(ld_en), .ld_value(ld_value)
   );

   // Reference counter built from R1-style reset value, R2 decrement and R3 load rules
   always_ff @(posedge wd_clk or negedge wd_rst_n) begin
      if (!wd_rst_n)      mdl <= 24'hFF;
      else if (ld_en)     mdl <= ld_value;
      else if (mdl != 0)  mdl <= mdl - 24'd1;
   end

   always @(negedge bus_clk) if (rd_valid) vcount++;

   function automatic bit in_range(input logic [23:0] v, input logic [23:0] lo,
                                   input logic [23:0] hi);
      return (v >= lo) && (v <= hi);
   endfunction

   task automatic check(input string req, input bit ok, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic load(input logic [23:0] v);
      @(negedge wd_clk); ld_en = 1'b1; ld_value = v;
      @(negedge wd_clk); ld_en = 1'b0;
   endtask

   task automatic wait_valid(output bit seen);
      seen = 0;
      for (int i = 0; i < 200; i++) begin
         @(negedge bus_clk);
         if (rd_valid) begin seen = 1; break; end
      end
   endtask

   // One read, checks R4, R5, R6, R7
   task automatic do_read(output logic [23:0] val);
      logic [23:0] hi, lo;
      realtime t0;
      bit seen;
      @(negedge bus_clk);
      hi = mdl; t0 = $realtime; rd_req = 1'b1;
      @(negedge bus_clk); rd_req = 1'b0;
      check("R4 busy after request", rd_busy === 1'b1, {31'd0, rd_busy}, 32'd1);
      wait_valid(seen);
      lo = mdl;
      val = rd_data[23:0];
      check("R4 valid seen", seen, {31'd0, seen}, 32'd1);
      check("R5 snapshot in range", in_range(rd_data[23:0], lo, hi), rd_data, {8'd0, hi});
      check("R6 reserved zero", rd_data[31:24] == 8'd0, rd_data, {8'd0, rd_data[23:0]});
      check("R7 latency", ($realtime - t0 - BUS_PER) <= (6*WD_PER + 6*BUS_PER),
            32'($rtoi($realtime - t0)), 32'($rtoi(6*WD_PER + 7*BUS_PER)));
      @(negedge bus_clk);
      check("R4 valid one cycle", rd_valid === 1'b0, {31'd0, rd_valid}, 32'd0);
      check("R4 busy cleared", rd_busy === 1'b0, {31'd0, rd_busy}, 32'd0);
   endtask

   initial begin
      logic [23:0] v, v2, hi2, lo2;
      bit seen;
      int base;
      void'($urandom(32'h1357_2468));
      repeat (4) @(negedge bus_clk);
      bus_rst_n = 1'b1; wd_rst_n = 1'b1;
      @(negedge bus_clk);
      // R1 reset state
      check("R1 reset data", rd_data === 32'h0000_00FF, rd_data, 32'hFF);
      check("R1 reset busy", rd_busy === 1'b0, {31'd0, rd_busy}, 32'd0);
      check("R1 reset valid", rd_valid === 1'b0, {31'd0, rd_valid}, 32'd0);

      // R1/R2 first read counts down from 0xFF
      do_read(v);
      check("R1 counts down from FF", v < 24'hFF, {8'd0, v}, 32'hFE);

      // R2 stops at zero, R3 load
      load(24'd3);
      repeat (20) @(negedge bus_clk);
      do_read(v);
      check("R2 holds at zero", v == 24'd0, {8'd0, v}, 32'd0);

      load(24'hFFFFFF);
      do_read(v);
      check("R3 load large value", v > 24'hFFFF00, {8'd0, v}, 32'hFFFFFF);

      // R8 data stable between reads
      repeat (30) @(negedge bus_clk);
      check("R8 data held", rd_data[23:0] == v, rd_data, {8'd0, v});

      // R9 held request
      base = vcount;
      @(negedge bus_clk); rd_req = 1'b1;
      @(negedge bus_clk); rd_req = 1'b1;
      @(negedge bus_clk); rd_req = 1'b0;
      hi2 = mdl;
      wait_valid(seen);
      v = rd_data[23:0];
      @(negedge bus_clk);
      check("R9 busy for held request", rd_busy === 1'b1, {31'd0, rd_busy}, 32'd1);
      wait_valid(seen);
      lo2 = mdl;
      v2 = rd_data[23:0];
      check("R9 second valid", seen, {31'd0, seen}, 32'd1);
      check("R9 second snapshot newer", v2 < v, {8'd0, v2}, {8'd0, v});
      check("R5 held snapshot in range", in_range(v2, lo2, hi2), {8'd0, v2}, {8'd0, hi2});
      repeat (40) @(negedge bus_clk);
      check("R9 two completions", vcount - base == 2, 32'(vcount - base), 32'd2);

      // R9 merge of extra requests
      base = vcount;
      @(negedge bus_clk); rd_req = 1'b1;
      repeat (3) @(negedge bus_clk);
      rd_req = 1'b0;
      repeat (80) @(negedge bus_clk);
      check("R9 merged requests", vcount - base == 2, 32'(vcount - base), 32'd2);
      check("R4 idle after merge", rd_busy === 1'b0, {31'd0, rd_busy}, 32'd0);

      // Random loads and gaps
      for (int k = 0; k < 40; k++) begin
         if ($urandom_range(0, 2) == 0) load(24'($urandom));
         else if ($urandom_range(0, 3) == 0) load(24'($urandom_range(0, 12)));
         repeat ($urandom_range(0, 15)) @(negedge bus_clk);
         do_read(v);
      end

      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #2_000_000;
      if (!finished) begin
         checks++; errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule